// File: doc/BRIEF.md
# Bit-Period Tick Generator

This block sets the bit timing for a serial transmitter and receiver. It runs entirely on the module clock. Its outputs are single-cycle enables, not derived clocks. A two-bit source select picks the tick source that feeds the divider. The source can be every module-clock cycle, a pulse from a fixed pre-divider, or the rising edge of an external clock pin after a synchronizer. A 16-bit divide value `CD` then counts source pulses to form the sampling tick.

In asynchronous mode, an oversampling counter takes every 8th sampling tick (`over` = 1) or every 16th (`over` = 0) and issues it as the baud tick. In synchronous mode the baud tick equals the sampling tick. The asynchronous baud rate is therefore source_rate / (8 × (2 − over) × CD). The fastest rate is one baud tick every 8 module cycles, using source 0 with `CD` = 1 and `over` = 1.

The configuration inputs are registered and presented back on outputs. Any change in a registered configuration field restarts all counters, so the first tick after a change comes one full period later.

Top module: `bitclk_gen`

## Requirements
- R1: While the registered divide value is 0, neither `samp_tick` nor `baud_tick` is asserted.
- R2: With divide value 1 the divider is bypassed: `samp_tick` follows every pulse of the selected source.
- R3: With divide value N ≥ 1, `samp_tick` pulses once every N source pulses.
- R4: Select code 0 uses every module-clock cycle as a source pulse.
- R5: Select code 1 uses one source pulse every `PRE_DIV` module cycles (default 8).
- R6: Select code 3 uses one source pulse per rising edge of `ext_clk`. The input passes through a two-stage synchronizer. Each high and low phase must last at least 5 module cycles.
- R7: Select code 2 is reserved and behaves exactly like code 0.
- R8: With `sync` = 0, `baud_tick` pulses on every 8th `samp_tick` when `over` = 1 and on every 16th when `over` = 0. Each `baud_tick` coincides with a `samp_tick`.
- R9: With `sync` = 1, `baud_tick` equals `samp_tick` on every cycle.
- R10: A change in any configuration field restarts the counters. If the inputs are first presented before rising edge k, the first `baud_tick` is high after edge k+1+X, where X = P·CD·(sync ? 1 : (over ? 8 : 16)) and P is the source period. The ticks then repeat every X cycles.
- R11: The `*_q` outputs equal the configuration inputs one clock later. Reset, which is synchronous and active high, clears every output to 0.
- R12: Every tick is a single-cycle pulse whenever the registered divide value is above 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cd | input | 16 | Divide value (0 off, 1 bypass) |
| cfg_src | input | 2 | Source select: 0 module clock, 1 pre-divided, 2 reserved, 3 external |
| cfg_over | input | 1 | Oversampling: 1 divides by 8, 0 divides by 16 |
| cfg_sync | input | 1 | 1 synchronous mode, 0 asynchronous mode |
| ext_clk | input | 1 | External clock pin, asynchronous |
| samp_tick | output | 1 | Sampling-clock enable pulse |
| baud_tick | output | 1 | Baud-rate enable pulse |
| cd_q | output | 16 | Registered divide value |
| src_q | output | 2 | Registered source select |
| over_q | output | 1 | Registered oversampling bit |
| sync_q | output | 1 | Registered mode bit |

## Verification
The configurations mix source (module clock, pre-divided, reserved code, external), divide value (1, 2 through 5) and mode (asynchronous by 8, asynchronous by 16, synchronous). A wrong period therefore points to a specific stage: source mux, divider or oversampler. Runs with divide value 1 separate bypass from an off-by-one count. The reserved-code run must match the module-clock timing. The external-clock runs check the period only, because their phase is free. The internal runs check the absolute cycle of the first tick after each restart. Before each configuration, an idle window with divide value 0 must show no ticks at all.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;
  typedef enum logic [1:0] {
    SRC_CORE = 2'd0,
    SRC_PRE  = 2'd1,
    SRC_RSVD = 2'd2,
    SRC_EXT  = 2'd3
  } src_sel_e;

  localparam int unsigned OVS_FAST = 8;
  localparam int unsigned OVS_SLOW = 16;
endpackage

// File: rtl/bitclk_src.sv
module bitclk_src
  import bitclk_pkg::*;
#(
  parameter int unsigned PRE_DIV     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     restart,
  input  logic     ext_in,
  input  src_sel_e src,
  output logic     src_en
);
  localparam int unsigned PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] pre_cnt;
  logic             pre_en;
  logic [SYNC_STAGES-1:0] sync_sh;
  logic             ext_prev;
  logic             ext_rise;

  // fixed pre-divider, realigned on restart
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_cnt <= '0;
    end else if (pre_cnt == PRE_LAST) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end
  assign pre_en = (pre_cnt == PRE_LAST);

  // synchronizer chain for the external pin
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_sh <= '0;
        else     sync_sh <= {sync_sh[SYNC_STAGES-2:0], ext_in};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_sh <= '0;
        else     sync_sh <= ext_in;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ext_prev <= 1'b0;
    else     ext_prev <= sync_sh[SYNC_STAGES-1];
  end
  assign ext_rise = sync_sh[SYNC_STAGES-1] & ~ext_prev;

  always_comb begin
    unique case (src)
      SRC_PRE: src_en = pre_en;
      SRC_EXT: src_en = ext_rise;
      default: src_en = 1'b1;  // core clock, reserved code aliases it
    endcase
  end
endmodule

// File: rtl/bitclk_cdiv.sv
module bitclk_cdiv #(
  parameter int unsigned CD_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            src_en,
  input  logic [CD_W-1:0] cd,
  output logic            samp_pulse
);
  logic [CD_W-1:0] cnt;
  logic [CD_W-1:0] cd_last;
  logic            off;
  logic            at_end;

  assign off     = (cd == '0);
  assign cd_last = cd - {{(CD_W-1){1'b0}}, 1'b1};
  assign at_end  = (cnt == cd_last);

  always_ff @(posedge clk) begin
    if (rst || restart || off) begin
      cnt <= '0;
    end else if (src_en) begin
      cnt <= at_end ? '0 : cnt + 1'b1;
    end
  end

  assign samp_pulse = src_en && !off && at_end && !restart;
endmodule

// File: rtl/bitclk_ovs.sv
module bitclk_ovs #(
  parameter int unsigned RATIO_HI = 16,
  parameter int unsigned RATIO_LO = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic samp_pulse,
  input  logic over,
  input  logic sync,
  output logic baud_pulse
);
  localparam int unsigned OW = $clog2(RATIO_HI);
  localparam logic [OW-1:0] LAST_HI = OW'(RATIO_HI - 1);
  localparam logic [OW-1:0] LAST_LO = OW'(RATIO_LO - 1);

  logic [OW-1:0] cnt;
  logic [OW-1:0] last;

  assign last = over ? LAST_LO : LAST_HI;

  always_ff @(posedge clk) begin
    if (rst || restart || sync) begin
      cnt <= '0;
    end else if (samp_pulse) begin
      cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end
  end

  assign baud_pulse = sync ? samp_pulse : (samp_pulse && (cnt == last));
endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen
  import bitclk_pkg::*;
#(
  parameter int unsigned CD_W        = 16,
  parameter int unsigned PRE_DIV     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CD_W-1:0] cfg_cd,
  input  logic [1:0]      cfg_src,
  input  logic            cfg_over,
  input  logic            cfg_sync,
  input  logic            ext_clk,
  output logic            samp_tick,
  output logic            baud_tick,
  output logic [CD_W-1:0] cd_q,
  output logic [1:0]      src_q,
  output logic            over_q,
  output logic            sync_q
);
  logic restart;
  logic src_en;
  logic samp_pulse;
  logic baud_pulse;
  logic cfg_moved;

  assign cfg_moved = (cfg_cd != cd_q) || (cfg_src != src_q) ||
                     (cfg_over != over_q) || (cfg_sync != sync_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cd_q    <= '0;
      src_q   <= '0;
      over_q  <= 1'b0;
      sync_q  <= 1'b0;
      restart <= 1'b0;
    end else begin
      cd_q    <= cfg_cd;
      src_q   <= cfg_src;
      over_q  <= cfg_over;
      sync_q  <= cfg_sync;
      restart <= cfg_moved;
    end
  end

  bitclk_src #(
    .PRE_DIV    (PRE_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_src (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .ext_in (ext_clk),
    .src    (src_sel_e'(src_q)),
    .src_en (src_en)
  );

  bitclk_cdiv #(
    .CD_W(CD_W)
  ) u_cdiv (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .src_en    (src_en),
    .cd        (cd_q),
    .samp_pulse(samp_pulse)
  );

  bitclk_ovs #(
    .RATIO_HI(OVS_SLOW),
    .RATIO_LO(OVS_FAST)
  ) u_ovs (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .samp_pulse(samp_pulse),
    .over      (over_q),
    .sync      (sync_q),
    .baud_pulse(baud_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_tick <= 1'b0;
      baud_tick <= 1'b0;
    end else begin
      samp_tick <= samp_pulse;
      baud_tick <= baud_pulse;
    end
  end
endmodule

// File: rtl/bitclk_gen_chk.sv
module bitclk_gen_chk #(
  parameter int unsigned CD_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [CD_W-1:0] cd_q,
  input logic [1:0]      src_q,
  input logic            over_q,
  input logic            sync_q,
  input logic            samp_tick,
  input logic            baud_tick
);
  logic [CD_W-1:0] cd_p;
  logic [1:0]      src_p;
  logic            over_p;
  logic            sync_p;
  logic            chg;
  logic [4:0]      samp_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cd_p <= '0; src_p <= '0; over_p <= 1'b0; sync_p <= 1'b0;
    end else begin
      cd_p <= cd_q; src_p <= src_q; over_p <= over_q; sync_p <= sync_q;
    end
  end
  assign chg = (cd_p != cd_q) || (src_p != src_q) || (over_p != over_q) || (sync_p != sync_q);

  always_ff @(posedge clk) begin
    if (rst || chg)     samp_run <= '0;
    else if (samp_tick) samp_run <= baud_tick ? 5'd0 : samp_run + 5'd1;
  end

  // R1
  cd_zero_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cd_q == '0) |=> (!samp_tick && !baud_tick));

  // R8
  baud_on_samp_chk: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> samp_tick);

  // R8
  ovs_ratio_chk: assert property (@(posedge clk) disable iff (rst)
    (baud_tick && !sync_q && !chg) |-> (samp_run == (over_q ? 5'd7 : 5'd15)));

  // R9
  sync_follow_chk: assert property (@(posedge clk) disable iff (rst)
    sync_q |=> (baud_tick == samp_tick));

  // R10
  restart_gap_chk: assert property (@(posedge clk) disable iff (rst)
    chg |=> !samp_tick);

  // R12
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (samp_tick && cd_q > 1) |=> !samp_tick);
endmodule

bind bitclk_gen bitclk_gen_chk #(.CD_W(CD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cd_q     (cd_q),
  .src_q    (src_q),
  .over_q   (over_q),
  .sync_q   (sync_q),
  .samp_tick(samp_tick),
  .baud_tick(baud_tick)
);

// File: tb/bitclk_gen_test.sv
module bitclk_gen_test;
  localparam int PRE = 8;
  localparam int EXT_HALF = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_cd = '0;
  logic [1:0]  cfg_src = '0;
  logic        cfg_over = 1'b0;
  logic        cfg_sync = 1'b0;
  logic        ext_clk = 1'b0;
  logic        samp_tick, baud_tick, over_q, sync_q;
  logic [15:0] cd_q;
  logic [1:0]  src_q;

  bitclk_gen #(.CD_W(16), .PRE_DIV(PRE), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .cfg_cd(cfg_cd), .cfg_src(cfg_src),
    .cfg_over(cfg_over), .cfg_sync(cfg_sync), .ext_clk(ext_clk),
    .samp_tick(samp_tick), .baud_tick(baud_tick), .cd_q(cd_q),
    .src_q(src_q), .over_q(over_q), .sync_q(sync_q)
  );

  always #4 clk = ~clk;

  initial begin
    forever begin
      repeat (EXT_HALF) @(negedge clk);
      ext_clk = ~ext_clk;
    end
  end

  typedef struct { int kind; int due; } exp_t; // kind 0 absolute, 1 interval, 2 skip
  exp_t   sb[$];
  int     checks = 0;
  int     fails = 0;
  int     cyc = 0;
  int     last_tick = 0;
  int     samp_seen = 0;
  int     exp_samp = 1;
  bit     quiet = 1'b1;
  bit     idle = 1'b0;
  string  tag = "R3";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops the scoreboard on each baud tick
  initial begin
    forever begin
      @(negedge clk);
      if (idle && (samp_tick || baud_tick))
        check(1'b0, "R1 tick while divide value is 0", 1, 0);
      if (samp_tick) samp_seen++;
      if (baud_tick) begin
        if (sb.size() == 0) begin
          if (!quiet && !idle) check(1'b0, {tag, " unexpected baud tick"}, 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (e.kind == 0)      check(cyc == e.due, {tag, " R10 first tick cycle"}, cyc, e.due);
          else if (e.kind == 1) check(cyc - last_tick == e.due, {tag, " tick period"}, cyc - last_tick, e.due);
          check(samp_seen == exp_samp, {tag, " R8 R9 sampling ticks per baud"}, samp_seen, exp_samp);
          last_tick = cyc;
        end
        samp_seen = 0;
      end
    end
  end

  task automatic run(input int src, input int cd, input bit over, input bit sync,
                     input int n, input string t);
    int p, x, c;
    p = (src == 1) ? PRE : (src == 3) ? 2 * EXT_HALF : 1;
    x = p * cd * (sync ? 1 : (over ? 8 : 16));
    quiet = 1'b1;
    @(negedge clk);
    cfg_cd = '0;
    repeat (4) @(negedge clk);
    quiet = 1'b0;
    idle = 1'b1;                 // R1 window
    repeat (20) @(negedge clk);
    check(!samp_tick && !baud_tick, "R1 idle at end of window", int'(samp_tick | baud_tick), 0);
    idle = 1'b0;
    tag = t;
    exp_samp = sync ? 1 : (over ? 8 : 16);
    samp_seen = 0;
    c = cyc;
    if (src == 3) sb.push_back('{2, 0});
    else          sb.push_back('{0, c + 2 + x});
    for (int i = 1; i < n; i++) sb.push_back('{1, x});
    cfg_cd = 16'(cd); cfg_src = 2'(src); cfg_over = over; cfg_sync = sync;
    @(negedge clk);
    check(cd_q == 16'(cd) && src_q == 2'(src) && over_q == over && sync_q == sync,
          "R11 registered config echo", int'(cd_q), cd);
    wait (sb.size() == 0);
    quiet = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!samp_tick && !baud_tick && cd_q == 0 && src_q == 0 && !over_q && !sync_q,
          "R11 reset state", int'(cd_q) + int'(samp_tick) + int'(baud_tick), 0);
    rst = 1'b0;
    run(0, 3, 1'b1, 1'b0, 3, "R4 R3 R8 core cd3 x8");
    run(0, 2, 1'b0, 1'b0, 3, "R4 R3 R8 core cd2 x16");
    run(1, 1, 1'b1, 1'b0, 2, "R5 R2 R8 prediv cd1 x8");
    run(0, 1, 1'b0, 1'b1, 6, "R2 R9 R4 core cd1 sync");
    run(0, 5, 1'b0, 1'b1, 4, "R3 R9 R12 core cd5 sync");
    run(2, 4, 1'b0, 1'b1, 4, "R7 reserved code cd4 sync");
    run(3, 2, 1'b0, 1'b1, 4, "R6 ext cd2 sync");
    run(3, 1, 1'b1, 1'b0, 3, "R6 R2 ext cd1 x8");
    run(1, 3, 1'b0, 1'b1, 3, "R5 R10 prediv cd3 sync");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule